// File: doc/BRIEF.md
# CAN Transceiver Mode and Transmit-Enable Supervisor

This block is the digital supervisor inside a CAN bus transceiver. It selects between an active mode, where the transmitter may drive the bus and the receive pin mirrors the bus state, and a low-power standby mode. In standby, transmit and receive are both switched off and the receive pin idles high. A wake-up flag from the analog low-power receiver, once seen, lets the receive pin track the bus again so that the host controller notices the activity.

The block also decides when the transmitter may drive dominant bits. Fault flags arrive already synchronized. A supply undervoltage forces standby, and so does an I/O supply undervoltage when that option is compiled in. A thermal fault only blocks the transmitter. After any thermal or supply fault, the transmitter is released only once the fault has gone away and the transmit data line has been sampled high. A dominant-timeout counter shuts the transmitter off when the transmit line stays low for too long. Every exit from standby passes through a fixed recovery interval. During that interval the transmitter stays off and the receive pin is held high.

Top module: `cantrx_supervisor`

## Requirements
- R1: While reset is active and directly after it, `mode` is 0 (standby), `tx_en` is 0 and `rxd` is 1.
- R2: In normal mode (`mode`=2) with no fault, no lockout and `txd` high, `tx_en` is 1 and `rxd` equals the inverse of `bus_dom` (1 = bus dominant).
- R3: In standby with no wake seen, `rxd` is 1 and `tx_en` is 0 whatever `bus_dom` is.
- R4: A `wake_det` sampled high in standby makes `rxd` equal to the inverse of `bus_dom` from the next cycle, for as long as standby lasts.
- R5: When the standby request goes away, `mode` reads 1 (recovery) for exactly RECOVER_CYC cycles and then 2. Throughout recovery, `tx_en` is 0 and `rxd` is 1.
- R6: `uv_vcc` high forces `mode` to 0 on the next edge and keeps it there, even with `stby_req` low.
- R7: With USE_IO_UV=1, `uv_vio` high forces standby in the same way as R6.
- R8: `over_temp` high clears `tx_en` from the next cycle, while `mode` stays 2 and `rxd` keeps following the bus.
- R9: A thermal lockout ends only at an edge where `over_temp` is low and `txd` is high. While `txd` stays low, `tx_en` stays 0 even after the flag has cleared.
- R10: After a supply undervoltage clears and recovery ends, `tx_en` remains 0 until `txd` has been sampled high.
- R11: When `txd` is sampled low on DOM_LIMIT consecutive edges, `tx_en` goes to 0. The first edge with `txd` high restores it, and shorter low runs never clear it.
- R12: `wake_det` outside standby has no effect. A wake seen in standby is forgotten once standby is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | Standby select: 1 requests standby, 0 requests normal |
| txd | input | 1 | Transmit data from controller, 0 = dominant |
| bus_dom | input | 1 | Receive comparator output, 1 = bus dominant |
| uv_vcc | input | 1 | Synchronized main supply undervoltage flag |
| uv_vio | input | 1 | Synchronized I/O supply undervoltage flag |
| over_temp | input | 1 | Synchronized overtemperature flag |
| wake_det | input | 1 | Valid wake-up pattern detected by low-power receiver |
| mode | output | 2 | 0 standby, 1 recovery, 2 normal |
| tx_en | output | 1 | Transmitter enable |
| rxd | output | 1 | Receive pin value toward controller |

## Verification
The hardest condition to produce is a lockout that outlives its fault. To reach it, a fault has to be raised and cleared while `txd` is held low. For the supply case, `txd` must also stay low across the whole recovery interval, yet the low run has to remain shorter than the dominant-timeout limit so that the two causes stay apart. The bench uses a recovery delay of 4 cycles and a timeout of 8, so it can hold `txd` low through a full recovery without tripping the timeout, and then release it on a known edge. It also sweeps every low-run length around the timeout limit and checks both bus levels in each mode.

// File: rtl/cantrx_pkg.sv
package cantrx_pkg;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_RECOV = 2'd1,
    MODE_NORM  = 2'd2
  } trx_mode_e;

  // Standby is requested by the pin or forced by a supply fault.
  function automatic logic standby_forced(input logic stby, input logic uv_main,
                                          input logic uv_io, input logic use_io);
    return stby | uv_main | (use_io & uv_io);
  endfunction

  // Receive pin level as a function of mode, wake memory and bus state.
  function automatic logic rxd_level(input trx_mode_e m, input logic woke,
                                     input logic bus_is_dom);
    logic lvl;
    case (m)
      MODE_NORM: lvl = ~bus_is_dom;
      MODE_STBY: lvl = woke ? ~bus_is_dom : 1'b1;
      default:   lvl = 1'b1;
    endcase
    return lvl;
  endfunction

  // Transmitter permission from its independent conditions.
  function automatic logic tx_allowed(input trx_mode_e m, input logic any_lock,
                                      input logic dom_timeout);
    return (m == MODE_NORM) & ~any_lock & ~dom_timeout;
  endfunction

endpackage

// File: rtl/cantrx_mode_fsm.sv
module cantrx_mode_fsm
  import cantrx_pkg::*;
#(
  parameter int RECOVER_CYC = 2000,
  parameter bit USE_IO_UV   = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stby_req,
  input  logic      uv_vcc,
  input  logic      uv_vio,
  output trx_mode_e mode_q,
  output logic      stby_eff
);
  localparam int CW = $clog2(RECOVER_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOVER_CYC - 1);

  logic [CW-1:0] rcnt_q;
  logic          recov_done;

  assign stby_eff   = standby_forced(stby_req, uv_vcc, uv_vio, USE_IO_UV);
  assign recov_done = (rcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STBY;
      rcnt_q <= '0;
    end else begin
      case (mode_q)
        MODE_STBY: begin
          rcnt_q <= '0;
          if (!stby_eff) mode_q <= MODE_RECOV;
        end
        MODE_RECOV: begin
          if (stby_eff) begin
            mode_q <= MODE_STBY;
            rcnt_q <= '0;
          end else if (recov_done) begin
            mode_q <= MODE_NORM;
            rcnt_q <= '0;
          end else begin
            rcnt_q <= rcnt_q + 1'b1;
          end
        end
        MODE_NORM: begin
          rcnt_q <= '0;
          if (stby_eff) mode_q <= MODE_STBY;
        end
        default: begin
          mode_q <= MODE_STBY;
          rcnt_q <= '0;
        end
      endcase
    end
  end

  AST_FORCE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    stby_eff |=> mode_q == MODE_STBY); // R6
  AST_RCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt_q <= LAST); // R5
  AST_RECOV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RECOV && !stby_eff && !recov_done) |=> mode_q == MODE_RECOV); // R5
  AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STBY) |=> mode_q != MODE_NORM); // R5

endmodule

// File: rtl/cantrx_lockout.sv
module cantrx_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic txd,
  output logic lock_q
);
  // Set by a fault; released only by an edge with no fault and TxD high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else if (fault) lock_q <= 1'b1;
    else if (txd) lock_q <= 1'b0;
  end

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> lock_q); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !txd) |=> lock_q); // R9

endmodule

// File: rtl/cantrx_dom_timer.sv
module cantrx_dom_timer #(
  parameter int DOM_LIMIT = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  output logic timeout_q
);
  localparam int DW = $clog2(DOM_LIMIT + 1);
  localparam logic [DW-1:0] LAST = DW'(DOM_LIMIT - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else if (txd) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else if (!timeout_q) begin
      if (cnt_q == LAST) timeout_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TO_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_q) |-> !$past(txd)); // R11
  AST_TO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    txd |=> !timeout_q); // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R11

endmodule

// File: rtl/cantrx_rx_path.sv
module cantrx_rx_path
  import cantrx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trx_mode_e mode,
  input  logic      wake_det,
  input  logic      bus_dom,
  output logic      wake_q,
  output logic      rxd
);
  // Wake memory lives only while in standby.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else if (mode == MODE_STBY) wake_q <= wake_q | wake_det;
    else wake_q <= 1'b0;
  end

  assign rxd = rxd_level(mode, wake_q, bus_dom);

  AST_WAKE_FORGET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_STBY) |=> !wake_q); // R12
  AST_WAKE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STBY && wake_det) |=> wake_q); // R4
  AST_STBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STBY && !wake_q) |-> rxd); // R3

endmodule

// File: rtl/cantrx_supervisor.sv
module cantrx_supervisor
  import cantrx_pkg::*;
#(
  parameter int RECOVER_CYC = 2000,
  parameter int DOM_LIMIT   = 2500,
  parameter bit USE_IO_UV   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       txd,
  input  logic       bus_dom,
  input  logic       uv_vcc,
  input  logic       uv_vio,
  input  logic       over_temp,
  input  logic       wake_det,
  output logic [1:0] mode,
  output logic       tx_en,
  output logic       rxd
);
  localparam int NUM_LOCK = 2;
  localparam int LK_THERM = 0;
  localparam int LK_SUPPLY = 1;

  trx_mode_e           mode_q;
  logic                stby_eff;
  logic                dom_to;
  logic                wake_q;
  logic                uv_any;
  logic [NUM_LOCK-1:0] fault_vec;
  logic [NUM_LOCK-1:0] lock_vec;
  logic                any_lock;

  cantrx_mode_fsm #(
    .RECOVER_CYC(RECOVER_CYC),
    .USE_IO_UV  (USE_IO_UV)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .stby_req(stby_req),
    .uv_vcc  (uv_vcc),
    .uv_vio  (uv_vio),
    .mode_q  (mode_q),
    .stby_eff(stby_eff)
  );

  assign uv_any = uv_vcc | (USE_IO_UV & uv_vio);
  assign fault_vec[LK_THERM]  = over_temp;
  assign fault_vec[LK_SUPPLY] = uv_any;

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_lock
    cantrx_lockout u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .fault (fault_vec[g]),
      .txd   (txd),
      .lock_q(lock_vec[g])
    );
  end

  assign any_lock = |lock_vec;

  cantrx_dom_timer #(.DOM_LIMIT(DOM_LIMIT)) u_dom (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .timeout_q(dom_to)
  );

  cantrx_rx_path u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .wake_det(wake_det),
    .bus_dom (bus_dom),
    .wake_q  (wake_q),
    .rxd     (rxd)
  );

  assign tx_en = tx_allowed(mode_q, any_lock, dom_to);
  assign mode  = mode_q;

  AST_RECOV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RECOV) |-> (!tx_en && rxd)); // R5
  AST_TX_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (mode_q == MODE_NORM)); // R2
  AST_THERM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> !tx_en); // R8
  AST_SUPPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any |=> (!tx_en && mode_q == MODE_STBY)); // R10

endmodule

// File: tb/cantrx_supervisor_tb.sv
module cantrx_supervisor_tb;
  localparam int RC = 4;
  localparam int DL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_req = 1'b1, txd = 1'b1, bus_dom = 1'b0;
  logic uv_vcc = 1'b0, uv_vio = 1'b0, over_temp = 1'b0, wake_det = 1'b0;
  logic [1:0] mode;
  logic tx_en, rxd;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cantrx_supervisor #(.RECOVER_CYC(RC), .DOM_LIMIT(DL), .USE_IO_UV(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .txd(txd), .bus_dom(bus_dom),
    .uv_vcc(uv_vcc), .uv_vio(uv_vio), .over_temp(over_temp), .wake_det(wake_det),
    .mode(mode), .tx_en(tx_en), .rxd(rxd)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic to_normal();
    stby_req = 1'b0;
    tick(RC + 1);
  endtask

  initial begin : watchdog
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    tick(3);
    chk("R1 mode in reset", mode, 0);
    chk("R1 tx_en in reset", tx_en, 0);
    chk("R1 rxd in reset", rxd, 1);
    rst_n = 1'b1;
    tick(1);
    chk("R1 mode after reset", mode, 0);
    chk("R1 tx_en after reset", tx_en, 0);

    for (int b = 0; b < 2; b++) begin
      bus_dom = b[0];
      #1;
      chk("R3 standby rxd idle", rxd, 1);
      chk("R3 standby tx off", tx_en, 0);
    end

    // R5: recovery length
    bus_dom = 1'b1;
    stby_req = 1'b0;
    for (int i = 1; i <= RC + 1; i++) begin
      tick(1);
      chk("R5 mode during exit", mode, (i <= RC) ? 1 : 2);
      if (i <= RC) begin
        chk("R5 tx_en low in recovery", tx_en, 0);
        chk("R5 rxd high in recovery", rxd, 1);
      end
    end

    for (int b = 0; b < 2; b++) begin
      bus_dom = b[0];
      #1;
      chk("R2 normal rxd", rxd, b == 0 ? 1 : 0);
      chk("R2 normal tx_en", tx_en, 1);
    end

    // R12: wake in normal ignored
    wake_det = 1'b1; tick(1); wake_det = 1'b0;
    bus_dom = 1'b1; stby_req = 1'b1; tick(1);
    chk("R12 mode standby", mode, 0);
    chk("R12 wake in normal ignored", rxd, 1);

    // R4 wake in standby
    wake_det = 1'b1; tick(1); wake_det = 1'b0; tick(2);
    for (int b = 0; b < 2; b++) begin
      bus_dom = b[0];
      #1;
      chk("R4 rxd follows after wake", rxd, b == 0 ? 1 : 0);
      chk("R4 tx off in standby", tx_en, 0);
    end
    bus_dom = 1'b1;
    stby_req = 1'b0; tick(1);
    chk("R5 rxd held in recovery after wake", rxd, 1);
    stby_req = 1'b1; tick(1);
    chk("R12 wake forgotten after leaving standby", rxd, 1);

    // R8 / R9 thermal
    to_normal();
    chk("R8 precondition normal", mode, 2);
    over_temp = 1'b1; tick(1);
    chk("R8 tx_en off on overtemp", tx_en, 0);
    chk("R8 mode stays normal", mode, 2);
    for (int b = 0; b < 2; b++) begin
      bus_dom = b[0];
      #1;
      chk("R8 rxd still follows", rxd, b == 0 ? 1 : 0);
    end
    over_temp = 1'b0; txd = 1'b0; tick(1);
    chk("R9 lock holds with txd low", tx_en, 0);
    tick(2);
    chk("R9 lock still holds", tx_en, 0);
    txd = 1'b1; tick(1);
    chk("R9 released by txd high", tx_en, 1);
    over_temp = 1'b1; tick(1);
    over_temp = 1'b0; tick(1);
    chk("R9 flag clear and txd high same edge", tx_en, 1);

    // R6 / R10 supply undervoltage
    uv_vcc = 1'b1; tick(1);
    chk("R6 forced standby", mode, 0);
    chk("R6 tx off", tx_en, 0);
    tick(3);
    chk("R6 stays standby with stby_req low", mode, 0);
    uv_vcc = 1'b0; txd = 1'b0;
    tick(RC + 1);
    chk("R10 back in normal", mode, 2);
    chk("R10 tx held until txd high", tx_en, 0);
    txd = 1'b1; tick(1);
    chk("R10 tx enabled after txd high", tx_en, 1);

    // R7 I/O undervoltage
    uv_vio = 1'b1; tick(1);
    chk("R7 io uv forces standby", mode, 0);
    uv_vio = 1'b0;
    tick(RC + 1);
    chk("R7 recovered to normal", mode, 2);
    chk("R7 tx on after recovery", tx_en, 1);

    // R11 dominant timeout sweep
    for (int n = 1; n <= DL + 2; n++) begin
      txd = 1'b0;
      tick(n);
      chk("R11 tx_en after low run", tx_en, (n < DL) ? 1 : 0);
      txd = 1'b1;
      tick(1);
      chk("R11 tx_en after release", tx_en, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule